// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical address into a DRAM rank selection for a memory controller with two channels of four ranks each. Software programs one 8-bit boundary per rank and a packed page-size attribute per rank pair through a small byte-wide write port. Each boundary is the running top of memory, in 32 MiB units, up to and including that rank. A rank whose boundary repeats the one before it holds no memory.

The block compares the two channels' programming on every cycle. When every boundary and every attribute field match, the channels are treated as interleaved. In that case only channel 0's four ranks are walked, and each of their boundaries counts double. Otherwise all eight ranks are walked as one asymmetric address space: channel 0's ranks first, then channel 1's.

A request presents an address. One clock later the block returns the winning rank, a miss flag, that rank's page-size code, and a flag raised when that code is a reserved value. The current mode and the total installed memory are also visible continuously.

Top module: `rank_addr_decoder`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the register selected by `cfg_addr`. Offsets 0 to 3 hold the channel 0 boundaries of ranks 0 to 3. Offsets 8 to 11 hold the channel 1 boundaries. Offset 4 holds the channel 0 attributes of ranks 0 and 1, and offset 5 those of ranks 2 and 3. Offsets 12 and 13 hold the same two attribute registers for channel 1. Attribute bits 7 and 3 are not stored. Writes to offsets 6, 7, 14 and 15 change nothing. Reset clears every register.
- R2: `ilv_mode` is 1 exactly when, for every rank, the boundaries and the stored attribute fields of the two channels are equal. After reset it is 1.
- R3: When `ilv_mode` is 0, the walk covers ranks 0 to 7. Ranks 4 to 7 are channel 1 ranks 0 to 3, and every boundary is used as written. The response rank is the lowest-numbered rank whose boundary, multiplied by 2^25, is greater than the request address.
- R4: A rank whose effective boundary equals that of the rank walked just before it is never selected. For rank 0, the rank walked before it counts as a boundary of 0.
- R5: When `ilv_mode` is 1, only ranks 0 to 3 are walked. They use channel 0's boundaries shifted left by one bit, so the rank index is always below 4.
- R6: When no walked rank matches, `rsp_miss` is 1, and `rsp_rank`, `rsp_page` and `rsp_attr_err` are all 0.
- R7: On a hit, `rsp_page` is the rank's 3-bit attribute field. Even ranks use bits 2:0 and odd ranks use bits 6:4 of the attribute register for the rank's channel and pair. The codes are 0 for unpopulated, 2 for 4 KB, 3 for 8 KB and 4 for 16 KB. In interleaved mode the channel is always channel 0.
- R8: On a hit whose code is 1, 5, 6 or 7, `rsp_attr_err` is 1 and `rsp_page` still carries that code. For any other code, `rsp_attr_err` is 0.
- R9: `rsp_valid` equals `req_valid` of the previous cycle. The response reflects the configuration as it stood before any write made in the request's cycle.
- R10: `mem_top` is the largest effective boundary among the walked ranks, in 32 MiB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | ADDR_W | Physical byte address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_rank | output | 3 | Selected rank |
| rsp_miss | output | 1 | Address beyond installed memory |
| rsp_page | output | 3 | Page-size code of selected rank |
| rsp_attr_err | output | 1 | Selected rank carries a reserved code |
| ilv_mode | output | 1 | Channels detected as interleaved |
| mem_top | output | 9 | Total memory in 32 MiB units |

## Verification
The hardest condition to reach is one where the mode, the empty-rank rule and the page lookup all depend on the same registers. A single mismatching field anywhere flips the whole rank space between four doubled ranks and eight plain ones. The bench therefore programs several complete configurations: all-zero, asymmetric with empty ranks in both channels, identical channels, and channels full of reserved codes. For each one it sweeps the address across every 32 MiB unit of the address space and compares against an arithmetic model. It also perturbs the configuration with writes that must not matter: unused offsets and unstored attribute bits. Finally, it issues a write in the same cycle as a request.

// File: rtl/rank_addr_decoder.sv
module rank_addr_decoder #(
  parameter int ADDR_W = 34,
  parameter int UNIT_SHIFT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_rank,
  output logic              rsp_miss,
  output logic [2:0]        rsp_page,
  output logic              rsp_attr_err,
  output logic              ilv_mode,
  output logic [8:0]        mem_top
);
  localparam int LW = ADDR_W + 1;

  logic [7:0] bnd  [8];
  logic [7:0] attr [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bnd[i] <= '0;
      for (int i = 0; i < 4; i++) attr[i] <= '0;
    end else if (cfg_we) begin
      if (!cfg_addr[2])
        bnd[{cfg_addr[3], cfg_addr[1:0]}] <= cfg_wdata;
      else if (!cfg_addr[1])
        attr[{cfg_addr[3], cfg_addr[0]}] <= cfg_wdata & 8'h77;
    end
  end

  always_comb begin
    ilv_mode = 1'b1;
    for (int i = 0; i < 4; i++)
      if (bnd[i] != bnd[4+i]) ilv_mode = 1'b0;
    for (int i = 0; i < 2; i++)
      if (attr[i] != attr[2+i]) ilv_mode = 1'b0;
  end

  logic [8:0] eff [8];
  logic [7:0] walked, empty;
  logic       hit;
  logic [2:0] rk;

  always_comb begin
    logic [8:0] prev;
    prev = '0;
    hit = 1'b0;
    rk = '0;
    mem_top = '0;
    for (int i = 0; i < 8; i++) begin
      walked[i] = !ilv_mode || (i < 4);
      eff[i] = ilv_mode ? {bnd[i & 3], 1'b0} : {1'b0, bnd[i]};
      empty[i] = (eff[i] == prev);
      prev = eff[i];
      if (walked[i] && eff[i] > mem_top) mem_top = eff[i];
      if (walked[i] && !empty[i] && !hit &&
          ({1'b0, req_addr} < (LW'(eff[i]) << UNIT_SHIFT))) begin
        hit = 1'b1;
        rk = 3'(i);
      end
    end
  end

  wire       sel_ch = ilv_mode ? 1'b0 : rk[2];
  wire [7:0] sel_a  = attr[{sel_ch, rk[1]}];
  wire [2:0] fld    = rk[0] ? sel_a[6:4] : sel_a[2:0];
  wire       rsvd   = (fld == 3'd1) || (fld > 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rank <= '0;
      rsp_miss <= 1'b0;
      rsp_page <= '0;
      rsp_attr_err <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rank <= hit ? rk : 3'd0;
        rsp_miss <= !hit;
        rsp_page <= hit ? fld : 3'd0;
        rsp_attr_err <= hit && rsvd;
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_rank == 3'd0 && rsp_page == 3'd0 && !rsp_attr_err)); // R6
  AST_ILV_LOW_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ilv_mode) |=> (rsp_rank < 3'd4)); // R5
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> (rsp_attr_err == (rsp_page == 3'd1 || rsp_page > 3'd4))); // R8
  AST_ERR_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_attr_err |-> !rsp_miss); // R8
endmodule

// File: tb/sim_rank_addr_decoder.sv
module sim_rank_addr_decoder;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic req_valid = 0;
  logic [33:0] req_addr = 0;
  logic rsp_valid, rsp_miss, rsp_attr_err, ilv_mode;
  logic [2:0] rsp_rank, rsp_page;
  logic [8:0] mem_top;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rank_addr_decoder u0 (.*);

  logic [7:0] mb [8];
  logic [7:0] ma [4];

  function automatic bit m_ilv();
    for (int i = 0; i < 4; i++) if (mb[i] != mb[4+i]) return 0;
    for (int i = 0; i < 2; i++) if (ma[i] != ma[2+i]) return 0;
    return 1;
  endfunction

  function automatic int m_eff(int i);
    return m_ilv() ? mb[i] * 2 : mb[i];
  endfunction

  function automatic int m_top();
    int t = 0;
    for (int i = 0; i < (m_ilv() ? 4 : 8); i++) if (m_eff(i) > t) t = m_eff(i);
    return t;
  endfunction

  task automatic m_dec(input longint a, output bit hit, output int rk, output int pg, output bit er);
    int prev = 0;
    hit = 0; rk = 0; pg = 0; er = 0;
    for (int i = 0; i < (m_ilv() ? 4 : 8); i++) begin
      int e = m_eff(i);
      if (!hit && e != prev && a < (longint'(e) * 64'd33554432)) begin
        int reg_i, f;
        hit = 1; rk = i;
        reg_i = (m_ilv() ? 0 : (i / 4) * 2) + ((i / 2) % 2);
        f = (i % 2) ? ((ma[reg_i] >> 4) & 7) : (ma[reg_i] & 7);
        pg = f;
        er = (f == 1) || (f > 4);
      end
      prev = e;
    end
  endtask

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
    if (a % 8 < 4) mb[(a / 8) * 4 + a % 8] = 8'(d);
    else if (a % 8 < 6) ma[(a / 8) * 2 + a % 8 - 4] = 8'(d) & 8'h77;
  endtask

  task automatic vec(string tag, longint a);
    bit h, e; int r, p;
    m_dec(a, h, r, p, e);
    @(negedge clk);
    req_valid = 1; req_addr = 34'(a);
    @(negedge clk);
    req_valid = 0;
    n_chk++;
    if (rsp_valid !== 1 || rsp_miss !== !h || rsp_rank !== 3'(r) ||
        rsp_page !== 3'(p) || rsp_attr_err !== e) begin
      n_bad++;
      $display("FAIL %s addr=%0h actual v%0b m%0b r%0d p%0d e%0b expected v1 m%0b r%0d p%0d e%0b",
               tag, a, rsp_valid, rsp_miss, rsp_rank, rsp_page, rsp_attr_err, !h, r, p, e);
    end
  endtask

  task automatic sweep(string tag);
    chk({tag, " R2 mode"}, ilv_mode, m_ilv());
    chk({tag, " R10 top"}, mem_top, m_top());
    for (int u = 0; u < 512; u++) begin
      longint off = (longint'(u) * 7919 * 4099) % 33554432;
      vec(tag, longint'(u) * 33554432 + ((u % 3 == 0) ? 0 : (u % 3 == 1) ? 33554431 : off));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mb[i] = 0;
    for (int i = 0; i < 4; i++) ma[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle valid", rsp_valid, 0);
    chk("R1 reset top", mem_top, 0);
    chk("R2 reset ilv", ilv_mode, 1);
    sweep("R1 R6 reset");

    wr(0, 4); wr(1, 4); wr(2, 12); wr(3, 16);
    wr(8, 20); wr(9, 20); wr(10, 20); wr(11, 40);
    wr(4, 8'h32); wr(5, 8'h42); wr(12, 8'h03); wr(13, 8'h20);
    sweep("R3 R4 R7 asym");
    wr(6, 8'hFF); wr(7, 8'h01); wr(14, 8'hFF); wr(15, 8'h00);
    sweep("R1 ignored offsets");

    for (int c = 0; c < 2; c++) begin
      wr(c * 8 + 0, 8); wr(c * 8 + 1, 16); wr(c * 8 + 2, 16); wr(c * 8 + 3, 100);
      wr(c * 8 + 4, 8'h43); wr(c * 8 + 5, 8'h02);
    end
    sweep("R5 R4 interleave");
    wr(13, 8'h8A);
    chk("R1 R2 masked bits", ilv_mode, 1);
    wr(11, 101);
    sweep("R2 R3 one-field mismatch");
    wr(11, 100);

    wr(0, 10); wr(1, 20); wr(2, 30); wr(3, 40);
    wr(8, 40); wr(9, 40); wr(10, 40); wr(11, 255);
    wr(4, 8'h51); wr(5, 8'h76); wr(12, 0); wr(13, 0);
    sweep("R8 reserved codes");

    @(negedge clk);
    req_valid = 1; req_addr = 34'(longint'(5) * 33554432);
    cfg_we = 1; cfg_addr = 4'd0; cfg_wdata = 8'd2;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk("R9 same-cycle write rank", rsp_rank, 0);
    chk("R9 same-cycle write page", rsp_page, 1);
    mb[0] = 2;
    vec("R9 after write", longint'(5) * 33554432);
    @(negedge clk);
    chk("R9 valid drops", rsp_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule